// File: doc/BRIEF.md
# Receive Buffer and Line Status Unit

This unit sits between a serial receive deserializer and the CPU register path of a 16550-style UART. Each completed character arrives on a one-cycle strobe together with its parity, framing and break flags. The unit keeps these characters in one of two stores. In single-register mode it uses one holding slot. In queued mode it uses a receive FIFO with a parameterized depth, which is 16 by default. Every entry carries its own error flags.

The CPU reads an 8-bit line status byte, returned zero-extended to 16 bits, and the oldest received character. It does this with two one-cycle read strobes. Reading the status byte clears the sticky error flags. Reading the buffer removes the head character. The unit also drives the receiver line status interrupt. The two transmitter bits are taken from the transmitter's status pins without change.

Top module: `rx_line_status`

## Requirements
- R1: Status bit positions are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 transmit holding empty (= `thr_empty`), 6 transmitter idle (= `tx_idle`), 7 queued error pending. Bits 15..8 always read 0.
- R2: After reset, with both transmitter inputs high, the status reads 0x0060 and the interrupt is low.
- R3: A character strobe always leaves data ready at 1 on the next cycle.
- R4: In single-register mode, a new character replaces the held one. A buffer read with no character arriving in the same cycle clears data ready.
- R5: In single-register mode, a character that arrives while data ready is 1 and no buffer read occurs in that cycle sets overrun.
- R6: In queued mode, overrun is set only when a character completes while the queue holds DEPTH entries and no buffer read occurs in that cycle. That character is dropped, and the stored entries and their order are kept.
- R7: A status read clears overrun unless a new overrun happens in the same cycle.
- R8: The parity, framing and break bits take the flags of a character when it becomes the head of the buffer. They stay set until a status read clears them.
- R9: In queued mode, data ready stays 1 until the last stored entry is read.
- R10: Bit 7 is 1 in queued mode while any stored entry has a parity, framing or break flag. It is always 0 in single-register mode.
- R11: The interrupt equals the enable input ANDed with the OR of status bits 1 to 4.
- R12: An error that is set in the same cycle as a status read stays set after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = queued mode, 0 = single holding register |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error flag of the character |
| char_ferr | input | 1 | Framing error flag of the character |
| char_brk | input | 1 | Break flag of the character |
| lsi_en | input | 1 | Line status interrupt enable |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmitter fully idle |
| rd_buf | input | 1 | One-cycle strobe: CPU reads the receive buffer |
| rd_lsr | input | 1 | One-cycle strobe: CPU reads the line status |
| rbuf_data | output | 8 | Character at the head of the buffer |
| lsr | output | 16 | Line status, upper byte zero |
| irq | output | 1 | Receiver line status interrupt |

## Verification
The checker runs on every cycle. It confirms the zero upper byte and the two transmitter pass-through bits. It confirms that a strobe always sets data ready and that the interrupt equation holds. It confirms that the status read clears overrun and the error bits, except when a new overrun or a new head character arrives in that cycle. It also confirms that the queue occupancy does not change when a character is dropped. Some behaviour can only be shown by the bench scenarios with known data. These are the overwrite in single-register mode, the exact order and contents of the queue after a dropped character, and the parity, framing and break flags appearing as a given entry reaches the head. They also include data ready staying high until the last entry is read, and the queued-error bit falling once the last bad entry leaves.

// File: rtl/rx_line_status_pkg.sv
package rx_line_status_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  localparam int NUM_ERR_FLAGS = 4;  // overrun, parity, framing, break

  // a character is "bad" if any of its per-character flags is set
  function automatic logic char_bad(rx_char_t c);
    return c.perr | c.ferr | c.brk;
  endfunction

  // assemble the status byte; bit order is what software decodes
  function automatic logic [7:0] pack_status(
      logic dr, logic [NUM_ERR_FLAGS-1:0] err, logic thre, logic temt, logic qerr);
    return {qerr, temt, thre, err[3], err[2], err[1], err[0], dr};
  endfunction

endpackage

// File: rtl/rx_store.sv
module rx_store
  import rx_line_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          wr_en,
  input  rx_char_t      wr_char,
  input  logic          rd_en,
  output rx_char_t      head,
  output logic [CW-1:0] occ,
  output logic          ovr_evt,
  output logic          head_load,
  output rx_char_t      head_next,
  output logic          any_bad
);

  rx_char_t       mem [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr, wr_addr;
  logic           pop, push;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  // is slot i currently holding a live entry?
  function automatic logic slot_live(int unsigned i, logic [PW-1:0] rp, logic [CW-1:0] cnt);
    logic [PW-1:0] off;
    off = PW'(i) - rp;
    return CW'(off) < cnt;
  endfunction

  always_comb begin
    pop       = rd_en && (occ != '0);
    head_next = wr_char;
    if (fifo_mode) begin
      ovr_evt   = wr_en && (occ == FULL) && !pop;
      push      = wr_en && !ovr_evt;
      head_load = (pop && occ > ONE) || (push && (occ == '0 || (pop && occ == ONE)));
      if (pop && occ > ONE) head_next = mem[rd_ptr + PW'(1)];
      wr_addr   = wr_ptr;
    end else begin
      ovr_evt   = wr_en && (occ != '0) && !pop;
      push      = wr_en;
      head_load = wr_en;
      wr_addr   = rd_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else if (fifo_mode) begin
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      if (push) wr_ptr <= wr_ptr + PW'(1);
      case ({push, pop})
        2'b10:   occ <= occ + ONE;
        2'b01:   occ <= occ - ONE;
        default: occ <= occ;
      endcase
    end else begin
      if (push)     occ <= ONE;
      else if (pop) occ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= wr_char;
  end

  assign head = mem[rd_ptr];

  always_comb begin
    any_bad = 1'b0;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      if (slot_live(i, rd_ptr, occ) && char_bad(mem[i])) any_bad = 1'b1;
    end
  end

endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;   // a new event wins over the clear
      else if (clr)    flags[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_line_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_mode,
  input  logic        char_valid,
  input  logic [7:0]  char_data,
  input  logic        char_perr,
  input  logic        char_ferr,
  input  logic        char_brk,
  input  logic        lsi_en,
  input  logic        thr_empty,
  input  logic        tx_idle,
  input  logic        rd_buf,
  input  logic        rd_lsr,
  output logic [7:0]  rbuf_data,
  output logic [15:0] lsr,
  output logic        irq
);

  rx_char_t                 in_char, head, head_next;
  logic [CW-1:0]            occ;
  logic                     ovr_evt, head_load, any_bad;
  logic [NUM_ERR_FLAGS-1:0] err_set, err_flags;
  logic                     data_ready, qerr;

  assign in_char = '{brk: char_brk, ferr: char_ferr, perr: char_perr, data: char_data};

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .wr_en     (char_valid),
    .wr_char   (in_char),
    .rd_en     (rd_buf),
    .head      (head),
    .occ       (occ),
    .ovr_evt   (ovr_evt),
    .head_load (head_load),
    .head_next (head_next),
    .any_bad   (any_bad)
  );

  assign err_set = {head_load & head_next.brk,
                    head_load & head_next.ferr,
                    head_load & head_next.perr,
                    ovr_evt};

  rx_flag_bank #(.N(NUM_ERR_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (rd_lsr),
    .flags (err_flags)
  );

  assign data_ready = (occ != '0);
  assign qerr       = fifo_mode & any_bad;
  assign rbuf_data  = head.data;
  assign lsr        = {8'h00, pack_status(data_ready, err_flags, thr_empty, tx_idle, qerr)};
  assign irq        = lsi_en & (|err_flags);

endmodule

// File: rtl/rx_line_status_chk.sv
module rx_line_status_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          char_valid,
  input logic          rd_buf,
  input logic          rd_lsr,
  input logic          lsi_en,
  input logic          thr_empty,
  input logic          tx_idle,
  input logic [15:0]   lsr,
  input logic          irq,
  input logic          ovr_evt,
  input logic          head_load,
  input logic [CW-1:0] occ
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[15:8] == 8'h00 && lsr[5] == thr_empty && lsr[6] == tx_idle);

  assert_strobe_sets_dr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> lsr[0]);

  assert_single_read_clears_dr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && rd_buf && !char_valid |=> !lsr[0]);

  assert_single_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && char_valid && lsr[0] && !rd_buf |=> lsr[1]);

  assert_drop_keeps_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && ovr_evt |=> occ == $past(occ));

  assert_read_clears_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr && !ovr_evt |=> !lsr[1]);

  assert_read_clears_errs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr && !head_load |=> lsr[4:2] == 3'b000);

  assert_dr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && rd_buf && occ > CW'(1) |=> lsr[0]);

  assert_qerr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !lsr[7]);

  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (lsi_en && (|lsr[4:1])));

  assert_new_oe_survives_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> lsr[1]);

endmodule

bind rx_line_status rx_line_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_mode  (fifo_mode),
  .char_valid (char_valid),
  .rd_buf     (rd_buf),
  .rd_lsr     (rd_lsr),
  .lsi_en     (lsi_en),
  .thr_empty  (thr_empty),
  .tx_idle    (tx_idle),
  .lsr        (lsr),
  .irq        (irq),
  .ovr_evt    (ovr_evt),
  .head_load  (head_load),
  .occ        (occ)
);

// File: tb/sim_rx_line_status.sv
`timescale 1ns/1ps
module sim_rx_line_status;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = '0;
  logic        char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
  logic        lsi_en = 1'b0;
  logic        thr_empty = 1'b1, tx_idle = 1'b1;
  logic        rd_buf = 1'b0, rd_lsr = 1'b0;
  logic [7:0]  rbuf_data;
  logic [15:0] lsr;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rx_line_status #(.DEPTH(DEPTH)) u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(logic [7:0] d, logic p, logic f, logic b);
    char_valid = 1'b1; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
    tick();
    char_valid = 1'b0; char_perr = 1'b0; char_ferr = 1'b0; char_brk = 1'b0;
  endtask

  task automatic read_buf();
    rd_buf = 1'b1; tick(); rd_buf = 1'b0;
  endtask

  task automatic read_lsr();
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset status", 32'(lsr), 32'h0060);
    chk("R2 reset irq", 32'(irq), 0);
    thr_empty = 1'b0; #1;
    chk("R1 thre follows input", 32'(lsr[5]), 0);
    chk("R1 upper byte", 32'(lsr[15:8]), 0);
    thr_empty = 1'b1; tx_idle = 1'b0; #1;
    chk("R1 temt follows input", 32'(lsr[6]), 0);
    tx_idle = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single();
    fifo_mode = 1'b0;
    put(8'hA5, 0, 0, 0);
    chk("R3 dr set", 32'(lsr[0]), 1);
    chk("R4 data", 32'(rbuf_data), 32'hA5);
    chk("R5 no overrun yet", 32'(lsr[1]), 0);
    put(8'h5A, 0, 0, 0);
    chk("R5 overrun set", 32'(lsr[1]), 1);
    chk("R4 overwritten", 32'(rbuf_data), 32'h5A);
    read_buf();
    chk("R4 dr cleared", 32'(lsr[0]), 0);
    read_lsr();
    chk("R7 oe cleared", 32'(lsr), 32'h0060);
  endtask

  task automatic t_errs();
    fifo_mode = 1'b0; lsi_en = 1'b1;
    put(8'h11, 1, 0, 0);
    chk("R8 parity shown", 32'(lsr[4:2]), 32'b001);
    chk("R11 irq on", 32'(irq), 1);
    chk("R10 qerr off in single mode", 32'(lsr[7]), 0);
    lsi_en = 1'b0; #1;
    chk("R11 irq masked", 32'(irq), 0);
    lsi_en = 1'b1;
    read_lsr();
    chk("R8 parity cleared", 32'(lsr[4:2]), 0);
    chk("R11 irq off", 32'(irq), 0);
    read_buf();
    put(8'h22, 0, 1, 1);
    chk("R8 frame+break", 32'(lsr[4:2]), 32'b110);
    read_lsr();
    read_buf();
    lsi_en = 1'b0;
  endtask

  task automatic t_fifo();
    fifo_mode = 1'b1;
    for (int i = 0; i < DEPTH; i++) put(8'(i * 3 + 1), 0, (i == 5), 0);
    chk("R8 head flags clean", 32'(lsr[4:2]), 0);
    chk("R10 qerr set", 32'(lsr[7]), 1);
    chk("R6 full but no overrun", 32'(lsr[1]), 0);
    put(8'hEE, 0, 0, 0);
    chk("R6 overrun on full", 32'(lsr[1]), 1);
    read_lsr();
    chk("R7 oe cleared", 32'(lsr[1]), 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 entry kept", 32'(rbuf_data), 32'(8'(i * 3 + 1)));
      if (i == 5) chk("R8 frame at head", 32'(lsr[3]), 1);
      chk("R10 qerr tracks", 32'(lsr[7]), 32'(i <= 5));
      read_buf();
      chk("R9 dr until last", 32'(lsr[0]), 32'(i < DEPTH - 1));
    end
    read_lsr();
  endtask

  task automatic t_same_cycle();
    fifo_mode = 1'b1;
    for (int i = 0; i < DEPTH; i++) put(8'(i), 0, 0, 0);
    char_valid = 1'b1; char_data = 8'hF0; rd_lsr = 1'b1;
    tick();
    char_valid = 1'b0; rd_lsr = 1'b0;
    chk("R12 overrun survives read", 32'(lsr[1]), 1);
    read_lsr();
    chk("R7 later read clears", 32'(lsr[1]), 0);
    char_valid = 1'b1; char_data = 8'hC3; rd_buf = 1'b1;
    tick();
    char_valid = 1'b0; rd_buf = 1'b0;
    chk("R6 push with pop not overrun", 32'(lsr[1]), 0);
    for (int i = 1; i < DEPTH; i++) read_buf();
    chk("R6 accepted last", 32'(rbuf_data), 32'hC3);
    read_buf();
    chk("R9 empty", 32'(lsr[0]), 0);
    char_valid = 1'b1; char_data = 8'h44; char_perr = 1'b1; rd_lsr = 1'b1;
    tick();
    char_valid = 1'b0; char_perr = 1'b0; rd_lsr = 1'b0;
    chk("R12 parity survives read", 32'(lsr[2]), 1);
    read_lsr();
    read_buf();
    chk("R7 idle status", 32'(lsr), 32'h0060);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_errs();
    t_fifo();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule